// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This unit forms the data-memory address for a 32-bit load/store pipeline. On a start strobe it takes a 2-bit mode, two register operand values and a 16-bit immediate, and produces the effective address. It also flags a word access that does not sit on a 4-byte boundary. Four modes are supported.

- **Displacement:** the first register plus the sign-extended immediate.
- **Indexed:** the sum of the two registers.
- **Auto-update:** displacement addressing that also hands the computed address back as a new base value, for a second register-file write.
- **Memory-indirect:** two dependent memory reads. The first read fetches a pointer and the second read uses that pointer.

Displacement, indexed and auto-update complete on the clock edge that accepts the start strobe. Memory-indirect runs a small sequencer through the memory request/ready handshake and reports completion one cycle after its second read is accepted. All address arithmetic wraps modulo 2^32 and no overflow is reported.

Top module: `lsea_unit`

## Requirements
- R1: With mode 0 (displacement), a start accepted at a clock edge makes `done` high for the following cycle, with `ea` equal to `rs_val` plus the immediate sign-extended from bit 15 to 32 bits, taken modulo 2^32.
- R2: With mode 1 (indexed), `ea` equals `rs_val + rt_val` modulo 2^32, with `done` timed as in R1; the immediate has no effect on the result.
- R3: With mode 2 (auto-update), `ea` is formed as in R1. In the same cycle as `done`, `wb_data` carries that same sum and `wb_en` is high for exactly that one cycle.
- R4: `misaligned` is high only in a `done` cycle, and there it is high exactly when bits 1:0 of `ea` are not both zero.
- R5: An auto-update access whose address is misaligned keeps `wb_en` low.
- R6: With mode 3 (memory-indirect), the cycle after the accepting edge has `mem_req` high and `mem_addr` equal to `rs_val` plus the sign-extended immediate. Request and address hold while `mem_ready` is low.
- R7: When the first read is accepted (`mem_ready` high), the next cycle requests the address given by the `mem_rdata` value returned with it. When the second read is accepted, the following cycle has `done` high for one cycle, `ea` equal to that pointer and `mem_req` low.
- R8: A start that arrives while a memory-indirect operation is in progress, from its first request cycle through its done cycle, is ignored: it produces no `done`, no `wb_en` and no change to the indirect sequence.
- R9: While reset is high and in the cycle after it, `done`, `wb_en`, `mem_req` and `misaligned` are low. Reset is synchronous and active high.
- R10: A displacement access with a zero immediate yields `ea` equal to `rs_val`, which is the register-direct case.
- R11: `wb_en` stays low for displacement, indexed and memory-indirect operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address computation |
| mode | input | 2 | 0 displacement, 1 indexed, 2 auto-update, 3 memory-indirect |
| rs_val | input | 32 | Base register value |
| rt_val | input | 32 | Index register value |
| imm | input | 16 | Two's-complement displacement |
| mem_rdata | input | 32 | Read data returned by memory |
| mem_ready | input | 1 | Memory accepts the current read this cycle |
| mem_addr | output | 32 | Address of the current memory read |
| mem_req | output | 1 | Memory read request |
| ea | output | 32 | Final effective address, valid with `done` |
| wb_data | output | 32 | Updated base value, valid with `wb_en` |
| wb_en | output | 1 | Base register write-back enable |
| done | output | 1 | Completion strobe |
| misaligned | output | 1 | Final address is not word aligned, valid with `done` |

## Verification
Errors in the sequencer state show up at the memory port the cycle after they occur.

- A state stuck in the pointer fetch keeps `mem_addr` on the displacement sum after the ready beat.
- A skipped pointer fetch requests the wrong address straight away.
- A state that never leaves its done phase repeats `done` or swallows the next start.

A stale or wrongly gated completion register shows up as a `done`, `wb_en` or `misaligned` value that disagrees with the reference model on the very next cycle. The bench therefore compares every output on every clock, rather than only at completion.

// File: rtl/lsea_pkg.sv
package lsea_pkg;

    localparam int unsigned LSEA_ADDR_W    = 32;
    localparam int unsigned LSEA_IMM_W     = 16;
    localparam int unsigned LSEA_ALIGN_LSB = 2;

    typedef enum logic [1:0] {
        AM_DISP     = 2'd0,
        AM_INDEX    = 2'd1,
        AM_UPDATE   = 2'd2,
        AM_INDIRECT = 2'd3
    } am_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_READ_PTR,
        SQ_READ_DATA,
        SQ_DONE
    } sq_state_e;

    function automatic logic mode_is_single(input am_mode_e m);
        return m != AM_INDIRECT;
    endfunction

    function automatic logic mode_writes_base(input am_mode_e m);
        return m == AM_UPDATE;
    endfunction

endpackage

// File: rtl/lsea_align_chk.sv
module lsea_align_chk #(
    parameter int unsigned ADDR_W    = lsea_pkg::LSEA_ADDR_W,
    parameter int unsigned ALIGN_LSB = lsea_pkg::LSEA_ALIGN_LSB
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              mis
);
    generate
        if (ALIGN_LSB == 0) begin : g_byte
            logic unused_addr;
            assign unused_addr = ^addr;
            assign mis = 1'b0;
        end else begin : g_word
            logic unused_hi;
            assign unused_hi = ^addr[ADDR_W-1:ALIGN_LSB];
            assign mis = |addr[ALIGN_LSB-1:0];
        end
    endgenerate
endmodule

// File: rtl/lsea_agen.sv
module lsea_agen
    import lsea_pkg::*;
#(
    parameter int unsigned ADDR_W = LSEA_ADDR_W,
    parameter int unsigned IMM_W  = LSEA_IMM_W
) (
    input  am_mode_e          mode,
    input  logic [ADDR_W-1:0] rs_val,
    input  logic [ADDR_W-1:0] rt_val,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] disp_sum,
    output logic [ADDR_W-1:0] sel_sum
);
    localparam int unsigned EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] imm_ext;
    logic [ADDR_W-1:0] addend;

    assign imm_ext  = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign disp_sum = rs_val + imm_ext;

    always_comb begin
        addend = (mode == AM_INDEX) ? rt_val : imm_ext;
    end

    assign sel_sum = rs_val + addend;
endmodule

// File: rtl/lsea_ind_seq.sv
module lsea_ind_seq
    import lsea_pkg::*;
#(
    parameter int unsigned ADDR_W = LSEA_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [ADDR_W-1:0] ptr_addr,
    input  logic              mem_ready,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              finish,
    output logic [ADDR_W-1:0] final_ea,
    output logic              idle
);
    sq_state_e         st_q, st_d;
    logic [ADDR_W-1:0] fetch_q;
    logic [ADDR_W-1:0] ptr_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_IDLE:      if (launch)    st_d = SQ_READ_PTR;
            SQ_READ_PTR:  if (mem_ready) st_d = SQ_READ_DATA;
            SQ_READ_DATA: if (mem_ready) st_d = SQ_DONE;
            SQ_DONE:                     st_d = SQ_IDLE;
            default:                     st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SQ_IDLE;
            fetch_q <= '0;
            ptr_q   <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == SQ_IDLE && launch)
                fetch_q <= ptr_addr;
            if (st_q == SQ_READ_PTR && mem_ready)
                ptr_q <= mem_rdata;
        end
    end

    always_comb begin
        unique case (st_q)
            SQ_READ_PTR:  mem_addr = fetch_q;
            SQ_READ_DATA: mem_addr = ptr_q;
            default:      mem_addr = '0;
        endcase
    end

    assign mem_req  = (st_q == SQ_READ_PTR) || (st_q == SQ_READ_DATA);
    assign finish   = (st_q == SQ_READ_DATA) && mem_ready;
    assign final_ea = ptr_q;
    assign idle     = (st_q == SQ_IDLE);

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_READ_PTR && !mem_ready) |=> (st_q == SQ_READ_PTR && $stable(mem_addr))); // R6
    AST_PTR_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_READ_PTR && mem_ready) |=> (mem_req && mem_addr == $past(mem_rdata))); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_DONE) |=> (st_q == SQ_IDLE)); // R7
endmodule

// File: rtl/lsea_unit.sv
module lsea_unit
    import lsea_pkg::*;
#(
    parameter int unsigned ADDR_W    = LSEA_ADDR_W,
    parameter int unsigned IMM_W     = LSEA_IMM_W,
    parameter int unsigned ALIGN_LSB = LSEA_ALIGN_LSB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] rs_val,
    input  logic [ADDR_W-1:0] rt_val,
    input  logic [IMM_W-1:0]  imm,
    input  logic [ADDR_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] ea,
    output logic [ADDR_W-1:0] wb_data,
    output logic              wb_en,
    output logic              done,
    output logic              misaligned
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << ALIGN_LSB) - 64'd1);

    am_mode_e          mode_e;
    logic [ADDR_W-1:0] disp_sum, sel_sum, ind_ea;
    logic              mis_sel, mis_ind;
    logic              seq_idle, seq_finish;
    logic              accept, take_single, launch;

    logic [ADDR_W-1:0] ea_q, wb_q;
    logic              done_q, wb_en_q, mis_q;

    assign mode_e = am_mode_e'(mode);

    lsea_agen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_agen (
        .mode     (mode_e),
        .rs_val   (rs_val),
        .rt_val   (rt_val),
        .imm      (imm),
        .disp_sum (disp_sum),
        .sel_sum  (sel_sum)
    );

    lsea_align_chk #(.ADDR_W(ADDR_W), .ALIGN_LSB(ALIGN_LSB)) u_chk_sel (
        .addr (sel_sum),
        .mis  (mis_sel)
    );

    lsea_align_chk #(.ADDR_W(ADDR_W), .ALIGN_LSB(ALIGN_LSB)) u_chk_ind (
        .addr (ind_ea),
        .mis  (mis_ind)
    );

    lsea_ind_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .ptr_addr  (disp_sum),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .finish    (seq_finish),
        .final_ea  (ind_ea),
        .idle      (seq_idle)
    );

    assign accept      = start && seq_idle;
    assign take_single = accept && mode_is_single(mode_e);
    assign launch      = accept && !mode_is_single(mode_e);

    always_ff @(posedge clk) begin
        if (rst) begin
            ea_q    <= '0;
            wb_q    <= '0;
            done_q  <= 1'b0;
            wb_en_q <= 1'b0;
            mis_q   <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            wb_en_q <= 1'b0;
            mis_q   <= 1'b0;
            if (take_single) begin
                ea_q    <= sel_sum;
                done_q  <= 1'b1;
                mis_q   <= mis_sel;
                wb_en_q <= mode_writes_base(mode_e) && !mis_sel;
                if (mode_writes_base(mode_e))
                    wb_q <= disp_sum;
            end else if (seq_finish) begin
                ea_q   <= ind_ea;
                done_q <= 1'b1;
                mis_q  <= mis_ind;
            end
        end
    end

    assign ea         = ea_q;
    assign wb_data    = wb_q;
    assign wb_en      = wb_en_q;
    assign done       = done_q;
    assign misaligned = mis_q;

    AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (done && wb_data == ea)); // R3
    AST_WB_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> !misaligned); // R5
    AST_MIS_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        misaligned |-> (done && (ea & LOW_MASK) != '0)); // R4
    AST_INDEX_SUM: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(start && seq_idle && mode == 2'd1)) |-> (done && ea == $past(rs_val + rt_val))); // R2
    AST_REQ_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !done); // R7
    AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (start && !seq_idle && !seq_finish) |=> !wb_en); // R8
endmodule

// File: tb/tb_lsea_unit.sv
module tb_lsea_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [31:0] rs_val = '0, rt_val = '0, mem_rdata = '0;
    logic [15:0] imm = '0;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr, ea, wb_data;
    logic        mem_req, wb_en, done, misaligned;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    lsea_unit dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .rs_val(rs_val), .rt_val(rt_val), .imm(imm),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_req(mem_req), .ea(ea),
        .wb_data(wb_data), .wb_en(wb_en), .done(done), .misaligned(misaligned)
    );

    // behavioural reference
    int          m_phase;
    logic [31:0] m_fetch, m_ptr, m_ea, m_wbd;
    logic        m_done, m_wben, m_mis;
    string       m_dtag = "R9";
    string       m_wtag = "R9";

    function automatic logic [31:0] sx(input logic [15:0] v);
        return 32'($signed(v));
    endfunction

    function automatic logic [31:0] mem_model(input logic [31:0] a);
        logic [31:0] p;
        p = a * 32'h9E37_79B1 + 32'h0000_1000;
        return a[4] ? p : {p[31:2], 2'b00};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_done = 0; m_wben = 0; m_mis = 0;
            m_dtag = "R9"; m_wtag = "R9";
        end else begin
            m_done = 0; m_wben = 0; m_mis = 0;
            m_dtag = "R1"; m_wtag = "R11";
            if (start && m_phase != 0) m_dtag = "R8";
            case (m_phase)
                0: if (start) begin
                    case (mode)
                        2'd0: begin
                            m_ea = rs_val + sx(imm);
                            m_dtag = (imm == 16'h0) ? "R10" : "R1";
                        end
                        2'd1: begin m_ea = rs_val + rt_val; m_dtag = "R2"; end
                        2'd2: begin
                            m_ea = rs_val + sx(imm); m_dtag = "R3";
                            m_wbd = m_ea;
                        end
                        default: begin m_fetch = rs_val + sx(imm); m_phase = 1; end
                    endcase
                    if (mode != 2'd3) begin
                        m_done = 1;
                        m_mis = (m_ea[1:0] != 2'b00);
                        m_wben = (mode == 2'd2) && !m_mis;
                        m_wtag = (mode == 2'd2) ? (m_mis ? "R5" : "R3") : "R11";
                    end
                end
                1: if (mem_ready) begin m_ptr = mem_rdata; m_phase = 2; end
                2: if (mem_ready) begin
                    m_ea = m_ptr; m_done = 1; m_mis = (m_ptr[1:0] != 2'b00);
                    m_dtag = "R7"; m_phase = 3;
                end
                default: m_phase = 0;
            endcase
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic exp_req;
        exp_req = (m_phase == 1) || (m_phase == 2);
        chk(m_dtag, "done", {31'b0, done}, {31'b0, m_done});
        chk("R4", "misaligned", {31'b0, misaligned}, {31'b0, m_mis});
        chk(m_wtag, "wb_en", {31'b0, wb_en}, {31'b0, m_wben});
        if (m_done) chk(m_dtag, "ea", ea, m_ea);
        if (m_wben) chk("R3", "wb_data", wb_data, m_wbd);
        chk(m_phase == 1 ? "R6" : "R7", "mem_req", {31'b0, mem_req}, {31'b0, exp_req});
        if (m_phase == 1) chk("R6", "mem_addr", mem_addr, m_fetch);
        if (m_phase == 2) chk("R7", "mem_addr", mem_addr, m_ptr);
    endtask

    task automatic step(input logic st, input logic [1:0] md, input logic [31:0] a,
                        input logic [31:0] b, input logic [15:0] im, input logic rdy);
        @(negedge clk);
        compare_all();
        start = st; mode = md; rs_val = a; rt_val = b; imm = im;
        mem_ready = rdy; mem_rdata = mem_model(mem_addr);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9", "reset done", {31'b0, done}, 32'd0);
        chk("R9", "reset wb_en", {31'b0, wb_en}, 32'd0);
        chk("R9", "reset mem_req", {31'b0, mem_req}, 32'd0);
        chk("R9", "reset misaligned", {31'b0, misaligned}, 32'd0);
        rst = 1'b0;
        // R1 displacement, positive / negative / wrapping
        step(1, 2'd0, 32'h0000_1000, 32'h0, 16'h0010, 0);
        step(1, 2'd0, 32'h0000_1000, 32'h0, 16'hFFF0, 0);
        step(1, 2'd0, 32'hFFFF_FFF0, 32'h0, 16'h0020, 0);
        // R10 zero offset
        step(1, 2'd0, 32'h0000_2468, 32'h5, 16'h0000, 0);
        // R2 indexed, immediate ignored
        step(1, 2'd1, 32'h0000_0100, 32'h24, 16'h7FFF, 0);
        step(1, 2'd1, 32'h8000_0000, 32'h8000_0004, 16'h8000, 0);
        // R3 / R5 update
        step(1, 2'd2, 32'h0000_4000, 32'h0, 16'h0008, 0);
        step(1, 2'd2, 32'h0000_4000, 32'h0, 16'h0006, 0);
        // R4 misaligned displacement
        step(1, 2'd0, 32'h0000_4000, 32'h0, 16'h0001, 0);
        step(0, 2'd0, 32'h0, 32'h0, 16'h0, 0);
        // R6 / R7 / R8 indirect with stalls and a start while busy
        step(1, 2'd3, 32'h0000_0200, 32'h0, 16'h0010, 0);
        step(0, 2'd0, 32'h0, 32'h0, 16'h0, 0);
        step(1, 2'd2, 32'h0000_0400, 32'h0, 16'h0004, 0);
        step(0, 2'd0, 32'h0, 32'h0, 16'h0, 1);
        step(1, 2'd1, 32'h0000_0010, 32'h10, 16'h0, 0);
        step(0, 2'd0, 32'h0, 32'h0, 16'h0, 1);
        step(1, 2'd0, 32'h0000_0040, 32'h0, 16'h4, 0);
        step(0, 2'd0, 32'h0, 32'h0, 16'h0, 0);
        // indirect with ready always high, then mixed traffic
        step(1, 2'd3, 32'h0000_0310, 32'h0, 16'hFFFC, 1);
        repeat (4) step(0, 2'd0, 32'h0, 32'h0, 16'h0, 1);
        for (int i = 0; i < 600; i++) begin
            step(($urandom_range(0, 2) != 0), 2'($urandom_range(0, 3)), $urandom(), $urandom(),
                 16'($urandom()), ($urandom_range(0, 3) != 0));
        end
        repeat (6) step(0, 2'd0, 32'h0, 32'h0, 16'h0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule